// File: doc/BRIEF.md
# Time-Slot Interchange Switch with Message Mode

This block reorders channel bytes between four input and four output TDM streams, one channel time slot per clock. All streams are presented in parallel, one byte per stream per slot. A frame pulse marks the slot that carries channel 0. Every incoming byte is stored in a data store with two banks. One bank fills with the current frame while the other, which holds the frame just completed, is read for output. The banks swap at each frame pulse.

For every output stream and slot, a connection store holds a 16-bit entry that picks what the slot carries. The choices are a switched byte from any source stream and channel, a constant byte held in the entry itself (message mode), a high-impedance slot, or a slot forced to all ones. A small host port writes and reads connection entries and reads the data store. Host writes go to a pending copy, which becomes active at the next frame pulse, so a frame never mixes two configurations.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high and until the first active clock after it, `slot_out`, `slot_hiz` and `host_rdata` are all zero.
- R2: An entry with bits 15..13 clear is a connection. Output stream o in slot k carries the byte received on stream `entry[12:11]`, channel `entry[10:8]`, during the previous frame. The output appears on the clock after slot k is presented.
- R3: The delay is constant, one frame plus one clock. This holds even when the source channel comes later in the frame than the output slot, so one output frame holds bytes from one input frame only.
- R4: An entry with bit 13 set, and bits 15 and 14 clear, puts the entry's own byte `entry[7:0]` on the output slot.
- R5: An entry with bit 15 set raises `slot_hiz` for that stream and slot, and drives the data byte to zero.
- R6: An entry with bit 14 set and bit 15 clear drives 0xFF with `slot_hiz` low.
- R7: When bits 15 and 14 are both set, high impedance wins and the R5 behaviour applies.
- R8: A host write to a connection entry (`host_wr` with `host_dm` low) does not change any output until the next frame pulse. From that frame on, it is in force.
- R9: A host read puts its result on `host_rdata` on the next clock and holds it until the next read. With `host_dm` low, the result is the last word written to entry `host_addr`, where the address is {stream[4:3], channel[2:0]}. With `host_dm` high, the result is the byte in the last completed frame for that stream and channel, in bits 7..0, with bits 15..8 zero.
- R10: A host write with `host_dm` high changes neither the data store nor any connection entry.
- R11: A frame pulse in any slot restarts the slot count at channel 0 and swaps the banks. Slot numbering then continues from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one channel slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | High in the slot that carries channel 0 |
| slot_in | input | 32 | Input bytes, stream s in bits [8s+7:8s] |
| slot_out | output | 32 | Output bytes, stream o in bits [8o+7:8o] |
| slot_hiz | output | 4 | Per-stream high-impedance strobe for an external driver |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_dm | input | 1 | 1 selects the data store, 0 the connection store |
| host_addr | input | 5 | {stream, channel} address |
| host_wdata | input | 16 | Connection entry to write |
| host_rdata | output | 16 | Registered read result |

## Verification
A reference model in the bench is compared with every output on every clock. It is driven first with an all-zero configuration, and then with a mapping that reverses the channel order and rotates the streams. That mapping separates a correct one-frame delay from reading the bank that is still filling. Next, stream-wide message bytes and a repeating mix of high-impedance, forced-high, both-set and switched slots show the priority between the four entry kinds. Host writes made in the middle of a frame, data-store writes that must be ignored, and an early frame pulse check when a new configuration takes hold and how the slot count realigns.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
    parameter int STREAMS = 4;
    parameter int CHANS   = 8;
    parameter int DW      = 8;

    localparam int SW    = (STREAMS > 1) ? $clog2(STREAMS) : 1;
    localparam int CW    = (CHANS > 1) ? $clog2(CHANS) : 1;
    localparam int AW    = SW + CW;
    localparam int NSLOT = 2 ** AW;

    // One connection entry; field order fixes the host word layout.
    typedef struct packed {
        logic          hiz;
        logic          high;
        logic          msg;
        logic [SW-1:0] src_s;
        logic [CW-1:0] src_c;
        logic [DW-1:0] msg_byte;
    } cm_entry_t;

    localparam int EW = $bits(cm_entry_t);
endpackage

// File: rtl/tsi_slot_timer.sv
`timescale 1ns/1ps
module tsi_slot_timer
    import tsi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_i,
    output logic [CW-1:0] slot_o,
    output logic          wbank_o
);
    typedef struct packed {
        logic [CW-1:0] nxt;
        logic          bank;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        slot_o   = frame_i ? '0 : s_q.nxt;
        wbank_o  = frame_i ? ~s_q.bank : s_q.bank;
        s_d.bank = wbank_o;
        s_d.nxt  = (slot_o == CW'(CHANS - 1)) ? '0 : slot_o + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R11
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (s_q.nxt == CW'(1 % CHANS)));

    // R3
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (s_q.bank != $past(s_q.bank)));

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> $stable(s_q.bank));
endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem
    import tsi_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wbank,
    input  logic [CW-1:0]                 slot,
    input  logic [STREAMS-1:0][DW-1:0]    wr_data,
    input  logic [STREAMS-1:0][AW-1:0]    rd_addr,
    output logic [STREAMS-1:0][DW-1:0]    rd_data,
    input  logic [AW-1:0]                 host_addr,
    output logic [DW-1:0]                 host_data
);
    logic [1:0][NSLOT-1:0][DW-1:0] mem_d, mem_q;
    logic rbank;

    always_comb begin
        rbank = ~wbank;
        mem_d = mem_q;
        for (int s = 0; s < STREAMS; s++) begin
            mem_d[wbank][{SW'(s), slot}] = wr_data[s];
        end
        for (int o = 0; o < STREAMS; o++) begin
            rd_data[o] = mem_q[rbank][rd_addr[o]];
        end
        host_data = mem_q[rbank][host_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem
    import tsi_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_i,
    input  logic [CW-1:0]                slot,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  cm_entry_t                    wr_entry,
    output cm_entry_t                    rd_entry,
    output cm_entry_t [STREAMS-1:0]      cur_entry
);
    typedef struct packed {
        cm_entry_t [NSLOT-1:0] shadow;
        cm_entry_t [NSLOT-1:0] active;
    } cm_t;

    cm_t s_d, s_q;
    cm_entry_t [NSLOT-1:0] eff;

    always_comb begin
        eff        = frame_i ? s_q.shadow : s_q.active;
        s_d.active = eff;
        s_d.shadow = s_q.shadow;
        if (wr_en) s_d.shadow[addr] = wr_entry;
        rd_entry = s_q.shadow[addr];
        for (int o = 0; o < STREAMS; o++) begin
            cur_entry[o] = eff[{SW'(o), slot}];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R8
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> $stable(s_q.active));

    // R8
    act_load_chk: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (s_q.active == $past(s_q.shadow)));
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch
    import tsi_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_i,
    input  logic [STREAMS*DW-1:0]   slot_in,
    output logic [STREAMS*DW-1:0]   slot_out,
    output logic [STREAMS-1:0]      slot_hiz,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic                    host_dm,
    input  logic [AW-1:0]           host_addr,
    input  logic [EW-1:0]           host_wdata,
    output logic [EW-1:0]           host_rdata
);
    typedef struct packed {
        logic [STREAMS-1:0][DW-1:0] dat;
        logic [STREAMS-1:0]         hiz;
        logic [EW-1:0]              rd;
    } out_t;

    out_t o_d, o_q;

    logic [CW-1:0]               slot;
    logic                        wbank;
    logic [STREAMS-1:0][DW-1:0]  in_w;
    logic [STREAMS-1:0][AW-1:0]  src_addr;
    logic [STREAMS-1:0][DW-1:0]  src_data;
    logic [DW-1:0]               dm_host;
    cm_entry_t                   cm_host;
    cm_entry_t [STREAMS-1:0]     cur;
    logic                        cm_wr;

    assign in_w  = slot_in;
    assign cm_wr = host_wr & ~host_dm;

    tsi_slot_timer u_tmr (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .slot_o  (slot),
        .wbank_o (wbank)
    );

    tsi_data_mem u_dm (
        .clk       (clk),
        .rst       (rst),
        .wbank     (wbank),
        .slot      (slot),
        .wr_data   (in_w),
        .rd_addr   (src_addr),
        .rd_data   (src_data),
        .host_addr (host_addr),
        .host_data (dm_host)
    );

    tsi_conn_mem u_cm (
        .clk       (clk),
        .rst       (rst),
        .frame_i   (frame_i),
        .slot      (slot),
        .wr_en     (cm_wr),
        .addr      (host_addr),
        .wr_entry  (cm_entry_t'(host_wdata)),
        .rd_entry  (cm_host),
        .cur_entry (cur)
    );

    always_comb begin
        o_d = o_q;
        for (int o = 0; o < STREAMS; o++) begin
            src_addr[o] = {cur[o].src_s, cur[o].src_c};
            o_d.hiz[o]  = 1'b0;
            if (cur[o].hiz) begin
                o_d.dat[o] = '0;
                o_d.hiz[o] = 1'b1;
            end else if (cur[o].high) begin
                o_d.dat[o] = {DW{1'b1}};
            end else if (cur[o].msg) begin
                o_d.dat[o] = cur[o].msg_byte;
            end else begin
                o_d.dat[o] = src_data[o];
            end
        end
        if (host_rd) begin
            o_d.rd = host_dm ? {{(EW-DW){1'b0}}, dm_host} : EW'(cm_host);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign slot_out   = o_q.dat;
    assign slot_hiz   = o_q.hiz;
    assign host_rdata = o_q.rd;

    for (genvar g = 0; g < STREAMS; g++) begin : g_hiz
        // R5
        hiz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            slot_hiz[g] |-> (slot_out[g*DW +: DW] == '0));
    end

    // R10
    dm_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_dm && !host_rd) |=> $stable(host_rdata));
endmodule

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
module tsi_switch_test;
    import tsi_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  frame_i = 1'b0;
    logic [STREAMS*DW-1:0] slot_in = '0;
    logic [STREAMS*DW-1:0] slot_out;
    logic [STREAMS-1:0]    slot_hiz;
    logic                  host_wr = 1'b0, host_rd = 1'b0, host_dm = 1'b0;
    logic [AW-1:0]         host_addr = '0;
    logic [EW-1:0]         host_wdata = '0;
    logic [EW-1:0]         host_rdata;

    always #4 clk = ~clk;

    tsi_switch uut (
        .clk(clk), .rst(rst), .frame_i(frame_i), .slot_in(slot_in),
        .slot_out(slot_out), .slot_hiz(slot_hiz), .host_wr(host_wr),
        .host_rd(host_rd), .host_dm(host_dm), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    int unsigned   lcg = 32'h1234_5678;
    int            phase = 0, nxt = 0, realign_win = 0;
    bit            dm_wr_seen = 0;
    logic [DW-1:0] last_f[NSLOT];
    logic [DW-1:0] cur_f[NSLOT];
    logic [EW-1:0] sh[NSLOT];
    logic [EW-1:0] ac[NSLOT];
    logic [DW-1:0] exp_dat[STREAMS];
    logic          exp_hiz[STREAMS];
    logic [EW-1:0] exp_rd = '0;
    string         tag_o[STREAMS];
    string         rd_tag = "R1";

    task automatic chk(string tag, logic [EW-1:0] act, logic [EW-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int o = 0; o < STREAMS; o++) begin
            chk(tag_o[o], EW'(slot_out[o*DW +: DW]), EW'(exp_dat[o]), $sformatf("data s%0d", o));
            chk(tag_o[o], EW'(slot_hiz[o]), EW'(exp_hiz[o]), $sformatf("hiz s%0d", o));
        end
        chk(rd_tag, host_rdata, exp_rd, "host_rdata");
    endtask

    task automatic step(bit force_fp, bit wr, bit rd, bit dm,
                        logic [AW-1:0] addr, logic [EW-1:0] wdata);
        bit fp;
        int slot;
        logic [DW-1:0] inb[STREAMS];
        fp = force_fp || (phase == 0);
        phase = fp ? (1 % CHANS) : ((phase + 1) % CHANS);
        if (force_fp && phase != 1 % CHANS) realign_win = 0;
        for (int s = 0; s < STREAMS; s++) begin
            lcg = lcg * 1664525 + 1013904223;
            inb[s] = lcg[23:16];
            slot_in[s*DW +: DW] = inb[s];
        end
        frame_i = fp; host_wr = wr; host_rd = rd; host_dm = dm;
        host_addr = addr; host_wdata = wdata;

        slot = fp ? 0 : nxt;
        nxt = (slot + 1) % CHANS;
        if (fp) begin
            for (int i = 0; i < NSLOT; i++) begin
                logic [DW-1:0] t;
                ac[i] = sh[i];
                t = last_f[i]; last_f[i] = cur_f[i]; cur_f[i] = t;
            end
        end
        for (int o = 0; o < STREAMS; o++) begin
            cm_entry_t e;
            int idx;
            idx = o * CHANS + slot;
            e = cm_entry_t'(ac[idx]);
            exp_hiz[o] = 1'b0;
            if (e.hiz) begin
                exp_dat[o] = '0; exp_hiz[o] = 1'b1;
                tag_o[o] = e.high ? "R7" : "R5";
            end else if (e.high) begin
                exp_dat[o] = '1; tag_o[o] = "R6";
            end else if (e.msg) begin
                exp_dat[o] = e.msg_byte; tag_o[o] = "R4";
            end else begin
                exp_dat[o] = last_f[int'(e.src_s) * CHANS + int'(e.src_c)];
                if (sh[idx] != ac[idx])          tag_o[o] = "R8";
                else if (realign_win > 0)        tag_o[o] = "R11";
                else if (int'(e.src_c) > slot)   tag_o[o] = "R3";
                else                             tag_o[o] = "R2";
            end
        end
        for (int s = 0; s < STREAMS; s++) cur_f[s * CHANS + slot] = inb[s];
        if (rd) begin
            if (dm) exp_rd = {{(EW-DW){1'b0}}, last_f[addr]};
            else    exp_rd = sh[addr];
            rd_tag = (dm && dm_wr_seen) ? "R10" : "R9";
        end
        if (wr && !dm) sh[addr] = wdata;
        if (wr && dm) dm_wr_seen = 1;
        if (realign_win > 0) realign_win--;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0);
    endtask

    function automatic logic [EW-1:0] mk(bit hz, bit hi, bit ms, int s, int c, int b);
        cm_entry_t e;
        e.hiz = hz; e.high = hi; e.msg = ms;
        e.src_s = SW'(s); e.src_c = CW'(c); e.msg_byte = DW'(b);
        return EW'(e);
    endfunction

    initial begin
        for (int i = 0; i < NSLOT; i++) begin
            last_f[i] = '0; cur_f[i] = '0; sh[i] = '0; ac[i] = '0;
        end
        for (int o = 0; o < STREAMS; o++) begin
            exp_dat[o] = '0; exp_hiz[o] = 1'b0; tag_o[o] = "R1";
        end
        repeat (3) @(negedge clk);
        compare_all();               // R1 reset state
        rst = 1'b0;

        idle(2 * CHANS);             // default all-zero configuration
        // R2/R3: rotate streams, reverse channels
        for (int o = 0; o < STREAMS; o++)
            for (int c = 0; c < CHANS; c++)
                step(0, 1, 0, 0, AW'(o * CHANS + c),
                     mk(0, 0, 0, (o + 1) % STREAMS, CHANS - 1 - c, 0));
        idle(3 * CHANS);
        // R4..R7: message stream and mixed slot kinds
        for (int c = 0; c < CHANS; c++) begin
            step(0, 1, 0, 0, AW'(1 * CHANS + c), mk(0, 0, 1, 0, 0, 8'hA0 + c));
            case (c % 4)
                0: step(0, 1, 0, 0, AW'(2 * CHANS + c), mk(1, 0, 0, 0, c, 0));
                1: step(0, 1, 0, 0, AW'(2 * CHANS + c), mk(0, 1, 0, 0, c, 0));
                2: step(0, 1, 0, 0, AW'(2 * CHANS + c), mk(1, 1, 1, 0, c, 8'h5A));
                default: step(0, 1, 0, 0, AW'(2 * CHANS + c), mk(0, 0, 0, 3, c, 0));
            endcase
        end
        idle(3 * CHANS);
        // R9: host readback of both stores
        for (int i = 0; i < NSLOT; i++) step(0, 0, 1, 0, AW'(i), '0);
        for (int i = 0; i < NSLOT; i++) step(0, 0, 1, 1, AW'(i), '0);
        // R10: data-store writes are ignored
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, AW'(i * 3), 16'hFFFF);
        for (int i = 0; i < NSLOT; i++) step(0, 0, 1, 1, AW'(i), '0);
        idle(CHANS);
        // R11: early frame pulse
        idle(3);
        realign_win = 2 * CHANS + 1;
        step(1, 0, 0, 0, '0, '0);
        idle(3 * CHANS);
        // further R8 writes mid-frame
        for (int i = 0; i < 12; i++)
            step(0, 1, 0, 0, AW'((i * 7) % NSLOT), mk(0, 0, 0, i % STREAMS, (i * 5) % CHANS, 0));
        idle(3 * CHANS);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule